// File: doc/BRIEF.md
# DDR2 Command-to-Data Latency Scheduler

This block sits beside the command issue logic of a DDR2 memory controller. Each READ or WRITE it receives is stamped with the clock cycle it arrives in. From that cycle the block works out when the command's data phase begins on the data bus. It then raises a read-window or write-window strobe for the two clock cycles that the four-beat, double-data-rate burst occupies. While a strobe is high, the command's tag is shown next to it.

Read data starts additive latency plus CAS latency cycles after the command. Write data starts one cycle earlier than that, so a single shifting slot pipeline serves both directions. The controller can use additive latency to issue commands ahead of their data. A command whose two-cycle window would land on a slot that is already reserved is refused: the conflict flag is raised in that same cycle and nothing is recorded. The two latency settings come from a configuration input that is only taken while nothing is pending.

A two-state controller governs when configuration is taken. `ST_IDLE` means no window is pending. In this state the configuration inputs are used directly and also captured. Accepting a command takes `ST_IDLE` to `ST_BUSY`. In `ST_BUSY` the captured settings are frozen. When no reservation is left beyond the slot being output and no new command is accepted, `ST_BUSY` returns to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `lat_sched`

## Requirements
- R1: A synchronous active-high `rst` clears every pending window and returns to `ST_IDLE`. In the cycle after the reset edge `rd_win`, `wr_win` and `conflict` are 0 and `win_tag` is 0, and windows that were reserved before the reset never appear.
- R2: A READ accepted in cycle T (`cmd_valid`=1, `cmd_wr`=0) makes `rd_win` high in exactly cycles T+AL+CL and T+AL+CL+1, with `win_tag` equal to the command's tag in both cycles.
- R3: A WRITE accepted in cycle T (`cmd_wr`=1) makes `wr_win` high in exactly cycles T+AL+CL-1 and T+AL+CL. With AL=0 this is CL-1.
- R4: A nonzero additive latency delays the windows of both READs and WRITEs by AL cycles, with the write window still one cycle ahead of the read window.
- R5: Windows of different commands may sit directly next to each other with no idle cycle between them. This holds for read after read and for write after read, and the later command raises no conflict.
- R6: If either cycle of an incoming command's window is already reserved, `conflict` is high in the command's own cycle and the command is dropped: no window with its tag ever appears and earlier windows are unchanged.
- R7: `conflict` is 0 in any cycle without `cmd_valid`, and in any cycle with `rst` high.
- R8: `cfg_cl` and `cfg_al` are taken only in `ST_IDLE`. A command accepted in `ST_BUSY` uses the settings captured in the last idle cycle. New settings take effect once the block is idle again.
- R9: `cfg_cl` (plain binary) below 3 acts as 3 and above 5 acts as 5. `cfg_al` (plain binary) above 4 acts as 4.
- R10: `rd_win` and `wr_win` are never high together. `win_tag` is 0 whenever neither is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A READ or WRITE is issued this cycle |
| cmd_wr | input | 1 | 1 = WRITE, 0 = READ |
| cmd_tag | input | TAG_W | Identifier carried to the data window |
| cfg_cl | input | CFG_W | CAS latency setting in cycles |
| cfg_al | input | CFG_W | Additive latency setting in cycles |
| conflict | output | 1 | Incoming command refused because of overlap (combinational) |
| rd_win | output | 1 | Current cycle carries read data |
| wr_win | output | 1 | Current cycle carries write data |
| win_tag | output | TAG_W | Tag of the command owning the current window |

## Verification
The assertions assume that `rst` is held high over the first clock edge and that `cmd_tag`, `cmd_wr` and `cmd_valid` settle between clock edges. They also take the two-beat check to depend on nothing but the reservation logic, so any command timing is legal input. The stimulus changes every input on the falling edge and starts every scenario from a reset. It changes the latency settings both while idle and while windows are pending, including out-of-range codes, so the freeze and clamp assertions see real traffic.

// File: rtl/lat_pkg.sv
package lat_pkg;

    // Controller states: nothing pending / windows pending
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } sched_state_t;

    // Control part of one reserved data-bus cycle
    typedef struct packed {
        logic valid;   // cycle is reserved
        logic first;   // first of the two burst cycles
        logic wr;      // 1 = write data, 0 = read data
    } slot_ctl_t;

endpackage

// File: rtl/lat_cfg.sv
module lat_cfg #(
    parameter int CFG_W  = 3,
    parameter int CL_MIN = 3,
    parameter int CL_MAX = 5,
    parameter int AL_MAX = 4,
    parameter int LAT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             live,      // idle: take inputs directly
    input  logic [CFG_W-1:0] cfg_cl,
    input  logic [CFG_W-1:0] cfg_al,
    output logic [LAT_W-1:0] rd_lat,
    output logic [LAT_W-1:0] wr_lat
);
    logic [LAT_W-1:0] cl_c, al_c, sum_c, sum_q;

    always_comb begin
        if (int'(cfg_cl) < CL_MIN)      cl_c = LAT_W'(CL_MIN);
        else if (int'(cfg_cl) > CL_MAX) cl_c = LAT_W'(CL_MAX);
        else                            cl_c = LAT_W'(cfg_cl);
        if (int'(cfg_al) > AL_MAX)      al_c = LAT_W'(AL_MAX);
        else                            al_c = LAT_W'(cfg_al);
        sum_c = cl_c + al_c;
    end

    always_ff @(posedge clk) begin
        if (rst)       sum_q <= LAT_W'(CL_MIN);
        else if (live) sum_q <= sum_c;
    end

    assign rd_lat = live ? sum_c : sum_q;
    assign wr_lat = rd_lat - LAT_W'(1);

    // Settings stay frozen across consecutive busy cycles
    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!live && $past(!live)) |-> $stable(rd_lat));

    // Effective read latency never leaves the clamped range
    assert_cfg_range_R9: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_lat) >= CL_MIN) && (int'(rd_lat) <= CL_MAX + AL_MAX));

endmodule

// File: rtl/lat_pipe.sv
module lat_pipe
    import lat_pkg::*;
#(
    parameter int DEPTH = 11,
    parameter int TAG_W = 4,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_wr,
    input  logic [TAG_W-1:0] cmd_tag,
    input  logic [LAT_W-1:0] lat,
    output logic             accept,
    output logic             conflict,
    output slot_ctl_t        head_ctl,
    output logic [TAG_W-1:0] head_tag,
    output logic             pending_next
);
    slot_ctl_t        ctl_q [DEPTH];
    slot_ctl_t        ctl_d [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [TAG_W-1:0] tag_d [DEPTH];
    logic [DEPTH-1:0] occ;
    logic [DEPTH:0]   span;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) occ[i] = ctl_q[i].valid;
    end

    // The two cycles the new burst would use, relative to now
    assign span     = (DEPTH+1)'(3) << lat;
    assign conflict = !rst && cmd_valid && |(span[DEPTH-1:0] & occ);
    assign accept   = !rst && cmd_valid && !conflict;
    assign pending_next = accept || |occ[DEPTH-1:1];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        slot_ctl_t        sh_ctl;
        logic [TAG_W-1:0] sh_tag;
        if (i < DEPTH-1) begin : g_mid
            assign sh_ctl = ctl_q[i+1];
            assign sh_tag = tag_q[i+1];
        end else begin : g_end
            assign sh_ctl = '0;
            assign sh_tag = '0;
        end
        always_comb begin
            ctl_d[i] = sh_ctl;
            tag_d[i] = sh_tag;
            if (accept && lat == LAT_W'(i + 1)) begin
                ctl_d[i] = '{valid: 1'b1, first: 1'b1, wr: cmd_wr};
                tag_d[i] = cmd_tag;
            end else if (accept && lat == LAT_W'(i)) begin
                ctl_d[i] = '{valid: 1'b1, first: 1'b0, wr: cmd_wr};
                tag_d[i] = cmd_tag;
            end
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q[i] <= '0;
                tag_q[i] <= '0;
            end else begin
                ctl_q[i] <= ctl_d[i];
                tag_q[i] <= tag_d[i];
            end
        end
    end

    assign head_ctl = ctl_q[0];
    assign head_tag = tag_q[0];

    // A refusal only ever answers an offered command
    assert_conflict_needs_cmd_R7: assert property (@(posedge clk) disable iff (rst)
        conflict |-> cmd_valid);

    // A burst's first cycle is always followed by its second
    assert_two_beat_R5: assert property (@(posedge clk) disable iff (rst)
        (head_ctl.valid && head_ctl.first) |=>
            (head_ctl.valid && !head_ctl.first && $stable(head_ctl.wr) && $stable(head_tag)));

endmodule

// File: rtl/lat_sched.sv
module lat_sched
    import lat_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int CFG_W  = 3,
    parameter int CL_MIN = 3,
    parameter int CL_MAX = 5,
    parameter int AL_MAX = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_wr,
    input  logic [TAG_W-1:0] cmd_tag,
    input  logic [CFG_W-1:0] cfg_cl,
    input  logic [CFG_W-1:0] cfg_al,
    output logic             conflict,
    output logic             rd_win,
    output logic             wr_win,
    output logic [TAG_W-1:0] win_tag
);
    localparam int RL_MAX = CL_MAX + AL_MAX;
    localparam int DEPTH  = RL_MAX + 2;
    localparam int LAT_W  = $clog2(DEPTH + 1);

    sched_state_t     state_q, state_d;
    logic             cfg_live, accept, pending_next;
    logic [LAT_W-1:0] rd_lat, wr_lat, cmd_lat;
    slot_ctl_t        head_ctl;
    logic [TAG_W-1:0] head_tag;

    lat_cfg #(
        .CFG_W(CFG_W), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX),
        .AL_MAX(AL_MAX), .LAT_W(LAT_W)
    ) cfg_i (
        .clk(clk), .rst(rst), .live(cfg_live),
        .cfg_cl(cfg_cl), .cfg_al(cfg_al),
        .rd_lat(rd_lat), .wr_lat(wr_lat)
    );

    assign cmd_lat = cmd_wr ? wr_lat : rd_lat;

    lat_pipe #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LAT_W(LAT_W)) pipe_i (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_tag(cmd_tag),
        .lat(cmd_lat), .accept(accept), .conflict(conflict),
        .head_ctl(head_ctl), .head_tag(head_tag),
        .pending_next(pending_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)        state_d = ST_BUSY;
            ST_BUSY: if (!pending_next) state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cfg_live = (state_q == ST_IDLE);
        rd_win   = head_ctl.valid && !head_ctl.wr;
        wr_win   = head_ctl.valid &&  head_ctl.wr;
        win_tag  = head_ctl.valid ? head_tag : '0;
    end

    // No data cycle is ever driven while the controller is idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (!rd_win && !wr_win));

endmodule

// File: tb/lat_sched_tb_top.sv
module lat_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = 4;
    // vector: {wr, cl[2:0], al[2:0], tag[3:0], lat[3:0]}
    localparam logic [14:0] VEC [6] = '{
        {1'b0, 3'd3, 3'd0, 4'd5,  4'd3},
        {1'b1, 3'd3, 3'd0, 4'd6,  4'd2},
        {1'b0, 3'd5, 3'd4, 4'd7,  4'd9},
        {1'b1, 3'd4, 3'd2, 4'd8,  4'd5},
        {1'b0, 3'd1, 3'd0, 4'd9,  4'd3},
        {1'b1, 3'd7, 3'd6, 4'd10, 4'd8}
    };

    logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0, cmd_wr = 1'b0;
    logic [TAG_W-1:0] cmd_tag = '0;
    logic [2:0] cfg_cl = 3'd3, cfg_al = 3'd0;
    logic conflict, rd_win, wr_win;
    logic [TAG_W-1:0] win_tag;

    int n_run = 0, n_fail = 0, cyc = 0;
    int exp_kind [64];
    int exp_tag  [64];
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    lat_sched dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
        .cmd_tag(cmd_tag), .cfg_cl(cfg_cl), .cfg_al(cfg_al),
        .conflict(conflict), .rd_win(rd_win), .wr_win(wr_win), .win_tag(win_tag)
    );

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d actual=%0d expected=%0d", req, what, cyc, act, expv);
        end
    endtask

    task automatic clear_exp();
        for (int i = 0; i < 64; i++) begin exp_kind[i] = 0; exp_tag[i] = 0; end
        cyc = 0;
    endtask

    // one clock: outputs compared with the model in the new cycle
    task automatic step();
        int kind;
        @(posedge clk);
        cyc++;
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        kind = (rd_win ? 1 : 0) + (wr_win ? 2 : 0);
        chk(kind == exp_kind[cyc], cur_req, "window kind", kind, exp_kind[cyc]);
        chk(int'(win_tag) == exp_tag[cyc], (exp_kind[cyc] == 0) ? "R10" : cur_req,
            "win_tag", int'(win_tag), exp_tag[cyc]);
        chk(conflict == 1'b0, "R7", "conflict without command", int'(conflict), 0);
    endtask

    task automatic do_reset();
        rst = 1'b1; cmd_valid = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;
        clear_exp();
    endtask

    task automatic issue(bit wr, int tag, int lat, bit exp_conf, string req);
        cmd_valid = 1'b1; cmd_wr = wr; cmd_tag = TAG_W'(tag);
        #1;
        chk(conflict == exp_conf, req, "conflict", int'(conflict), int'(exp_conf));
        if (!exp_conf) begin
            exp_kind[cyc+lat] = wr ? 2 : 1; exp_tag[cyc+lat] = tag;
            exp_kind[cyc+lat+1] = wr ? 2 : 1; exp_tag[cyc+lat+1] = tag;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        clear_exp();
        do_reset();
        // R1: state right after reset
        chk(!rd_win && !wr_win, "R1", "window after reset", int'({rd_win, wr_win}), 0);
        chk(win_tag == '0, "R1", "tag after reset", int'(win_tag), 0);
        chk(conflict == 1'b0, "R1", "conflict after reset", int'(conflict), 0);

        // Table: single commands, R2/R3 basic, R4 additive latency, R9 clamping
        for (int v = 0; v < 6; v++) begin
            do_reset();
            cfg_cl = VEC[v][13:11];
            cfg_al = VEC[v][10:8];
            cur_req = (v < 2) ? (VEC[v][14] ? "R3" : "R2") : ((v < 4) ? "R4" : "R9");
            issue(VEC[v][14], int'(VEC[v][7:4]), int'(VEC[v][3:0]), 1'b0, cur_req);
            repeat (13) step();
        end

        // R5: read, read, write placed back to back
        do_reset();
        cfg_cl = 3'd3; cfg_al = 3'd0; cur_req = "R5";
        issue(1'b0, 1, 3, 1'b0, "R5");
        step(); step();
        issue(1'b0, 2, 3, 1'b0, "R5");
        step(); step(); step();
        issue(1'b1, 3, 2, 1'b0, "R5");
        repeat (8) step();

        // R6: overlapping commands refused and dropped
        do_reset();
        cfg_cl = 3'd3; cfg_al = 3'd0; cur_req = "R6";
        issue(1'b0, 1, 3, 1'b0, "R6");
        step();
        issue(1'b1, 2, 2, 1'b1, "R6");
        step();
        issue(1'b0, 3, 3, 1'b0, "R6");
        step();
        issue(1'b1, 4, 2, 1'b1, "R6");
        repeat (8) step();

        // R8: settings changed while busy are ignored until idle
        do_reset();
        cfg_cl = 3'd3; cfg_al = 3'd0; cur_req = "R8";
        issue(1'b0, 1, 3, 1'b0, "R8");
        step();
        cfg_cl = 3'd5; cfg_al = 3'd4;
        step();
        issue(1'b0, 2, 3, 1'b0, "R8");
        repeat (6) step();
        issue(1'b0, 3, 9, 1'b0, "R8");
        repeat (12) step();

        // R1/R7: reset while windows pending, with an overlapping command offered
        do_reset();
        cfg_cl = 3'd3; cfg_al = 3'd0; cur_req = "R1";
        issue(1'b0, 5, 3, 1'b0, "R1");
        step(); step();
        rst = 1'b1; cmd_valid = 1'b1; cmd_wr = 1'b1; cmd_tag = 4'd6;
        #1;
        chk(conflict == 1'b0, "R7", "conflict during reset", int'(conflict), 0);
        @(posedge clk); @(negedge clk);
        rst = 1'b0; cmd_valid = 1'b0;
        clear_exp();
        #1;
        chk(!rd_win && !wr_win, "R1", "window after mid reset", int'({rd_win, wr_win}), 0);
        repeat (6) step();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule